// File: doc/BRIEF.md
# Serial Tuning-Word Loader for a DDS Synthesizer

This block drives an external direct digital synthesizer over a three-wire serial link: serial data, write clock and frequency-update strobe, plus a chip reset line. An upstream sequencer presents a 32-bit frequency tuning word and two control flags, the reference-multiplier enable and the power-down request, and strobes `in_valid` while `ready` is high. The block assembles a 40-bit word from the tuning word and a control byte, shifts it out least significant bit first, and then pulses the update strobe so that the synthesizer adopts the new frequency.

After a system reset the block first holds the chip reset line high, then gives one write-clock pulse and one update pulse, which switch the synthesizer into serial loading. Only then does `ready` rise. A word offered while a transfer is in progress is ignored. The serial bit period and the widths of the reset and update pulses are parameters, so the link speed can be matched to the board.

Top module: `dds_serial_loader`

## Requirements
- R1: While `rst` is high, and for exactly RST_CYCLES clocks after it falls, `dds_reset` is high and `ready`, `dds_wclk` and `dds_fqud` are low.
- R2: Between the end of the reset pulse and the first rise of `ready`, exactly one `dds_wclk` pulse and then exactly one `dds_fqud` pulse occur.
- R3: A word is taken in the cycle where `in_valid` and `ready` are both high; `ready` is low in the next cycle and stays low until the transfer, update pulse included, has ended.
- R4: The serial word is the tuning word in bits 31..0 and the control byte in bits 39..32, sent LSB first: tuning-word bit 0 is the first bit and control bit 7 the last.
- R5: Control byte: bit 0 equals `in_mult6`, bit 1 is 0, bit 2 equals `in_pdown`, bits 7..3 (output phase) are 0.
- R6: `dds_sdata` does not change while `dds_wclk` is high, and each write-clock high phase lasts HALF_CYCLES clocks.
- R7: Each accepted word produces exactly 40 rising edges of `dds_wclk`.
- R8: After the 40th write clock has returned low, `dds_fqud` pulses high for exactly FUD_CYCLES clocks (at least 2); `ready` rises only after that pulse.
- R9: `in_valid` while `ready` is low has no effect: the word in flight is unchanged and no further transfer starts.
- R10: `dds_fqud` and `dds_wclk` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe from the sequencer |
| in_ftw | input | 32 | Frequency tuning word |
| in_mult6 | input | 1 | Enable the reference multiplier |
| in_pdown | input | 1 | Request synthesizer power-down |
| ready | output | 1 | High when a new word can be taken |
| dds_sdata | output | 1 | Serial data to the synthesizer |
| dds_wclk | output | 1 | Serial write clock |
| dds_fqud | output | 1 | Frequency-update strobe |
| dds_reset | output | 1 | Synthesizer reset |

## Verification
A wrong sequencer state shows up at the pins within one serial bit period: a bit counter that is off by one changes the count of write-clock edges or moves the update pulse relative to the last clock, and a shift register that is loaded or shifted at the wrong time places bits of the tuning word or control byte in the wrong positions of the captured 40-bit word. A timer fault changes the measured width of the reset, write-clock or update pulses as soon as the next one occurs. A state that accepts words while busy is caught by checking that strobes offered during a transfer leave both the captured word and the edge count untouched.

// File: rtl/dds_ser_pkg.sv
package dds_ser_pkg;

  typedef enum logic [3:0] {
    ST_RST,
    ST_INIT_CLK,
    ST_INIT_GAP,
    ST_INIT_UPD,
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_TAIL,
    ST_UPD
  } seq_st_t;

  localparam int CTRL_W = 8;

  // Control byte: multiplier enable at bit 0, bit 1 fixed low,
  // power-down at bit 2, output phase (bits 7..3) held at zero.
  function automatic logic [CTRL_W-1:0] build_ctrl(input logic mult6, input logic pdown);
    logic [CTRL_W-1:0] c;
    c    = '0;
    c[0] = mult6;
    c[2] = pdown;
    return c;
  endfunction

endpackage

// File: rtl/dds_phase_timer.sv
module dds_phase_timer #(
  parameter int TW       = 4,
  parameter int INIT_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= TW'(INIT_LEN - 1);
    else if (load)       cnt <= len - TW'(1);
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dds_shift_reg.sv
module dds_shift_reg #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         lsb
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {1'b0, q[W-1:1]};
  end

  assign lsb = q[0];
endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
  import dds_ser_pkg::*;
#(
  parameter int FTW_W       = 32,
  parameter int HALF_CYCLES = 2,
  parameter int RST_CYCLES  = 6,
  parameter int FUD_CYCLES  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FTW_W-1:0] in_ftw,
  input  logic             in_mult6,
  input  logic             in_pdown,
  output logic             ready,
  output logic             dds_sdata,
  output logic             dds_wclk,
  output logic             dds_fqud,
  output logic             dds_reset
);
  localparam int WORD_W = FTW_W + CTRL_W;
  localparam int BW     = $clog2(WORD_W);
  localparam int MAXL_A = (RST_CYCLES > HALF_CYCLES) ? RST_CYCLES : HALF_CYCLES;
  localparam int MAXL   = (MAXL_A > FUD_CYCLES) ? MAXL_A : FUD_CYCLES;
  localparam int TW     = $clog2(MAXL + 1);

  seq_st_t       state, state_n;
  logic [BW-1:0] bitcnt, bitcnt_n;
  logic          t_load, t_done;
  logic [TW-1:0] t_len;
  logic          sr_load, sr_shift;

  dds_phase_timer #(.TW(TW), .INIT_LEN(RST_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .len  (t_len),
    .done (t_done)
  );

  dds_shift_reg #(.W(WORD_W)) u_sreg (
    .clk   (clk),
    .rst   (rst),
    .load  (sr_load),
    .shift (sr_shift),
    .din   ({build_ctrl(in_mult6, in_pdown), in_ftw}),
    .lsb   (dds_sdata)
  );

  always_comb begin
    state_n  = state;
    bitcnt_n = bitcnt;
    t_load   = 1'b0;
    t_len    = TW'(HALF_CYCLES);
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    case (state)
      ST_RST: if (t_done) begin
        state_n = ST_INIT_CLK; t_load = 1'b1;
      end
      ST_INIT_CLK: if (t_done) begin
        state_n = ST_INIT_GAP; t_load = 1'b1;
      end
      ST_INIT_GAP: if (t_done) begin
        state_n = ST_INIT_UPD; t_load = 1'b1; t_len = TW'(FUD_CYCLES);
      end
      ST_INIT_UPD: if (t_done) state_n = ST_IDLE;
      ST_IDLE: if (in_valid) begin
        state_n  = ST_BIT_LO;
        t_load   = 1'b1;
        sr_load  = 1'b1;
        bitcnt_n = '0;
      end
      ST_BIT_LO: if (t_done) begin
        state_n = ST_BIT_HI; t_load = 1'b1;
      end
      ST_BIT_HI: if (t_done) begin
        sr_shift = 1'b1;
        t_load   = 1'b1;
        if (bitcnt == BW'(WORD_W - 1)) begin
          state_n = ST_TAIL;
        end else begin
          state_n  = ST_BIT_LO;
          bitcnt_n = bitcnt + BW'(1);
        end
      end
      ST_TAIL: if (t_done) begin
        state_n = ST_UPD; t_load = 1'b1; t_len = TW'(FUD_CYCLES);
      end
      ST_UPD: if (t_done) state_n = ST_IDLE;
      default: state_n = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RST;
      bitcnt    <= '0;
      ready     <= 1'b0;
      dds_wclk  <= 1'b0;
      dds_fqud  <= 1'b0;
      dds_reset <= 1'b1;
    end else begin
      state     <= state_n;
      bitcnt    <= bitcnt_n;
      ready     <= (state_n == ST_IDLE);
      dds_wclk  <= (state_n == ST_BIT_HI) || (state_n == ST_INIT_CLK);
      dds_fqud  <= (state_n == ST_UPD) || (state_n == ST_INIT_UPD);
      dds_reset <= (state_n == ST_RST);
    end
  end
endmodule

// File: rtl/dds_serial_loader_chk.sv
module dds_serial_loader_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic ready,
  input logic dds_sdata,
  input logic dds_wclk,
  input logic dds_fqud,
  input logic dds_reset
);
  p_reset_hold_r1: assert property (@(posedge clk) $fell(rst) |-> (dds_reset && !ready && !dds_wclk && !dds_fqud))
    else $error("reset state wrong after reset release");

  p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst) (in_valid && ready) |=> !ready)
    else $error("ready stayed high after accept");

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst) ready |-> (!dds_wclk && !dds_fqud && !dds_reset))
    else $error("link active while ready");

  p_data_stable_r6: assert property (@(posedge clk) disable iff (rst) (dds_wclk && $past(dds_wclk)) |-> $stable(dds_sdata))
    else $error("serial data moved while clock high");

  p_fqud_width_r8: assert property (@(posedge clk) disable iff (rst) $fell(dds_fqud) |-> ($past(dds_fqud, 2) && !dds_wclk))
    else $error("update strobe shorter than two clocks");

  p_excl_r10: assert property (@(posedge clk) disable iff (rst) !(dds_fqud && dds_wclk))
    else $error("update strobe overlaps write clock");
endmodule

bind dds_serial_loader dds_serial_loader_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .ready     (ready),
  .dds_sdata (dds_sdata),
  .dds_wclk  (dds_wclk),
  .dds_fqud  (dds_fqud),
  .dds_reset (dds_reset)
);

// File: tb/tb_dds_serial_loader.sv
module tb_dds_serial_loader;
  localparam int HALF = 2;
  localparam int RSTC = 6;
  localparam int FUDC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_ftw = '0;
  logic        in_mult6 = 1'b0;
  logic        in_pdown = 1'b0;
  logic        ready, dds_sdata, dds_wclk, dds_fqud, dds_reset;

  int checks = 0;
  int errors = 0;

  dds_serial_loader #(.FTW_W(32), .HALF_CYCLES(HALF), .RST_CYCLES(RSTC), .FUD_CYCLES(FUDC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ftw(in_ftw),
    .in_mult6(in_mult6), .in_pdown(in_pdown), .ready(ready),
    .dds_sdata(dds_sdata), .dds_wclk(dds_wclk), .dds_fqud(dds_fqud), .dds_reset(dds_reset)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl(input logic m6, input logic pd);
    logic [7:0] e;
    e = 8'h00;
    if (m6) e = e | 8'h01;
    if (pd) e = e | 8'h04;
    return e;
  endfunction

  // Pin monitor, sampled away from the active edge
  logic [39:0] cap = '0;
  int  nrise = 0, nfq = 0, hi_len = 0, fq_len = 0, last_fq_len = 0;
  int  rise_at_fq = 0, nreset_hi = 0;
  logic pw = 1'b0, pf = 1'b0, ps = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dds_reset) nreset_hi++;
      if (dds_wclk && dds_fqud) chk(1'b0, "R10 overlap", 1, 0);
      if (dds_wclk && !pw) begin
        cap = {dds_sdata, cap[39:1]};
        nrise++;
        hi_len = 1;
      end else if (dds_wclk && pw) begin
        hi_len++;
        if (dds_sdata !== ps) chk(1'b0, "R6 data moved in high phase", dds_sdata, ps);
      end
      if (!dds_wclk && pw) chk(hi_len == HALF, "R6 high width", hi_len, HALF);
      if (dds_fqud && !pf) begin nfq++; fq_len = 1; rise_at_fq = nrise; end
      else if (dds_fqud) fq_len++;
      if (!dds_fqud && pf) last_fq_len = fq_len;
      pw = dds_wclk; pf = dds_fqud; ps = dds_sdata;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic send(input logic [31:0] f, input logic m6, input logic pd, input bit poke);
    int r0, q0;
    logic [39:0] exp;
    wait_ready();
    r0 = nrise; q0 = nfq;
    exp = {exp_ctrl(m6, pd), f};
    in_ftw = f; in_mult6 = m6; in_pdown = pd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(ready == 1'b0, "R3 ready low after accept", ready, 0);
    in_ftw = ~f; in_mult6 = ~m6; in_pdown = ~pd;
    if (poke) begin
      repeat (17) @(negedge clk);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(ready == 1'b0, "R9 still busy", ready, 0);
      repeat (60) @(negedge clk);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
    end
    wait_ready();
    chk(nrise - r0 == 40, "R7 edge count", nrise - r0, 40);
    chk(cap[31:0] == exp[31:0], "R4 tuning word", cap[31:0], exp[31:0]);
    chk(cap[39:32] == exp[39:32], "R5 control byte", cap[39:32], exp[39:32]);
    chk(nfq - q0 == 1, "R8 one update pulse", nfq - q0, 1);
    chk(last_fq_len == FUDC, "R8 update width", last_fq_len, FUDC);
    chk(rise_at_fq == nrise, "R8 update after last clock", rise_at_fq, nrise);
    repeat (8) @(negedge clk);
    chk(ready && (nrise - r0 == 40), "R9 no extra transfer", nrise - r0, 40);
  endtask

  initial begin
    process::self().srandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    chk(dds_reset && !ready && !dds_wclk && !dds_fqud, "R1 state during reset",
        {dds_reset, ready, dds_wclk, dds_fqud}, 4'b1000);
    rst = 1'b0;
    wait_ready();
    chk(nreset_hi == RSTC, "R1 reset pulse length", nreset_hi, RSTC);
    chk(nrise == 1, "R2 init clock pulses", nrise, 1);
    chk(nfq == 1, "R2 init update pulses", nfq, 1);
    chk(rise_at_fq == 1, "R2 clock before update", rise_at_fq, 1);

    // Directed corners
    send(32'h0000_0001, 1'b1, 1'b0, 1'b0);
    send(32'h8000_0000, 1'b0, 1'b1, 1'b0);
    send(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    send(32'h0000_0000, 1'b0, 1'b0, 1'b1);
    // Random words, some with strobes offered mid-transfer
    for (int i = 0; i < 30; i++) begin
      send($urandom, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 2) == 0));
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule